// File: doc/BRIEF.md
# Directory Home Coherence Controller

This block is the home node of a small directory-based coherence scheme. Caches unicast their coherence requests (read-shared, read-for-ownership, write-back of a modified line) to it, and it also receives data returned by a previous owner. For each tracked block it keeps a directory entry: a coherence state, the identity of the current owner and a vector of sharers. For each request it either answers with data from its internal memory array, or forwards the request to the cache that owns the line, or sends invalidations to the other sharers. Because it handles one request at a time and updates the entry when it accepts that request, it is the single point that orders all transactions for a block. It relies on the network keeping message order between any two nodes.

A per-block busy flag covers the one case where the home must wait. When a read-shared request hits a modified line, the home forwards it to the owner and marks the block busy until the owner's copy of the data comes back. The main state machine has four states. FSM_IDLE accepts a request, decides the action and writes the directory entry. It then moves to FSM_RSP when a response is due, to FSM_FWD when a forward is due, or stays in FSM_IDLE for a data return. FSM_RSP sends one response and then goes to FSM_INV if invalidations are pending, or back to FSM_IDLE. FSM_INV sends one invalidation per remaining sharer and returns to FSM_IDLE after the last one. FSM_FWD sends one forward and returns to FSM_IDLE.

Request kinds: GetS=0, GetM=1, PutM=2, OwnerData=3. Forward kinds: FwdGetS=0, FwdGetM=1, Inv=2. Response kinds: Data=0, Ack=1. Internal entry states: I=2'b00, S=2'b01, M=2'b10.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is in I with no sharers and no busy flag, block `a` of memory holds the value `a`, `req_ready` is 1 and no output is valid.
- R2: A GetS to a block in I or S returns a Data response to the requestor with the memory value and an ack count of 0. The block becomes S and the requestor is added to its sharers.
- R3: A GetM to a block in I returns Data with an ack count of 0, and the block becomes M with the requestor as owner.
- R4: A GetM to a block in S first returns Data with an ack count equal to the number of sharers other than the requestor. It then sends one Inv to each of those sharers in ascending cache-id order, each carrying the requestor id in `fwd_req`. The block becomes M, owned by the requestor.
- R5: A GetM from a non-owner to a block in M sends FwdGetM to the owner with the requestor id. It sends no response, and the requestor becomes the owner.
- R6: A GetS from a non-owner to a block in M sends FwdGetS to the owner. The block becomes S with both the old owner and the requestor as sharers, and the block is marked busy.
- R7: While a block is busy, GetS, GetM and PutM to that block are not accepted (`req_ready` = 0), while requests to other blocks are accepted. An OwnerData to the busy block is accepted, writes its data to memory, clears the flag and produces no output.
- R8: A PutM from the owner of a block in M writes its data to memory, returns the block to I and answers with Ack.
- R9: A PutM from any cache that is not the owner is answered with Ack, and its data and the entry are left unchanged.
- R10: A GetS or GetM from the current owner of a block in M is answered with Ack and leaves the entry unchanged.
- R11: An OwnerData to a block that is not busy is ignored: it produces no output and does not change memory.
- R12: A valid response or forward holds all of its fields until it is accepted. Only one request is in progress at a time.
- R13: A block never has an owner and a sharer at once: after a GetM completes, a later request from another cache sees only the new owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | GetS=0, GetM=1, PutM=2, OwnerData=3 |
| req_src | input | $clog2(N_CACHE) | Sending cache id |
| req_addr | input | $clog2(N_BLK) | Block index |
| req_data | input | DATA_W | Write-back or returned data |
| fwd_valid | output | 1 | Forward or invalidation present |
| fwd_ready | input | 1 | Receiver accepts the forward |
| fwd_kind | output | 2 | FwdGetS=0, FwdGetM=1, Inv=2 |
| fwd_dest | output | $clog2(N_CACHE) | Target cache |
| fwd_req | output | $clog2(N_CACHE) | Original requestor id |
| fwd_addr | output | $clog2(N_BLK) | Block index |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Receiver accepts the response |
| rsp_kind | output | 1 | Data=0, Ack=1 |
| rsp_dest | output | $clog2(N_CACHE) | Target cache |
| rsp_addr | output | $clog2(N_BLK) | Block index |
| rsp_data | output | DATA_W | Block data (0 for Ack) |
| rsp_acks | output | $clog2(N_CACHE) | Invalidation acks the requestor must collect |

## Verification
A wrong directory entry does not show at once. It shows on the next request to the same block, which then gets the wrong message kind, the wrong target, a wrong ack count or extra invalidations. The bench therefore re-touches each block after every kind of change and compares every message against a behavioural model on the clock edge it is accepted. A stale busy flag shows within one cycle as `req_ready` stuck low. A lost memory write shows in the data of the next Data response for that block.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {REQ_GETS = 2'd0, REQ_GETM = 2'd1, REQ_PUTM = 2'd2, REQ_ODATA = 2'd3} req_kind_e;
    typedef enum logic [1:0] {FWD_GETS = 2'd0, FWD_GETM = 2'd1, FWD_INV = 2'd2} fwd_kind_e;
    typedef enum logic       {RSP_DATA = 1'b0, RSP_ACK = 1'b1} rsp_kind_e;
    typedef enum logic [1:0] {DIR_I = 2'd0, DIR_S = 2'd1, DIR_M = 2'd2} dir_st_e;
    typedef enum logic [1:0] {FSM_IDLE, FSM_RSP, FSM_FWD, FSM_INV} fsm_e;
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_BLK   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(N_BLK)-1:0]   addr,
    output logic [1:0]                 rd_st,
    output logic [$clog2(N_CACHE)-1:0] rd_own,
    output logic [N_CACHE-1:0]         rd_sh,
    output logic                       rd_busy,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_st,
    input  logic [$clog2(N_CACHE)-1:0] wr_own,
    input  logic [N_CACHE-1:0]         wr_sh,
    input  logic                       busy_set,
    input  logic                       busy_clr
);
    localparam int ID_W = $clog2(N_CACHE);

    logic [1:0]         st_q   [N_BLK];
    logic [ID_W-1:0]    own_q  [N_BLK];
    logic [N_CACHE-1:0] sh_q   [N_BLK];
    logic [N_BLK-1:0]   busy_q;

    assign rd_st   = st_q[addr];
    assign rd_own  = own_q[addr];
    assign rd_sh   = sh_q[addr];
    assign rd_busy = busy_q[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BLK; i++) begin
                st_q[i]  <= DIR_I;
                own_q[i] <= '0;
                sh_q[i]  <= '0;
            end
            busy_q <= '0;
        end else begin
            if (wr_en) begin
                st_q[addr]  <= wr_st;
                own_q[addr] <= wr_own;
                sh_q[addr]  <= wr_sh;
            end
            if (busy_set)      busy_q[addr] <= 1'b1;
            else if (busy_clr) busy_q[addr] <= 1'b0;
        end
    end

    for (genvar g = 0; g < N_BLK; g++) begin : g_entry_chk
        // R13: an owned block carries no sharers
        p_owner_alone_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == DIR_M) |-> (sh_q[g] == '0));
        // R2: a shared block has at least one sharer
        p_shared_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == DIR_S) |-> (sh_q[g] != '0));
        // R7: only a block waiting for owner data in S can be busy
        p_busy_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q[g] |-> (st_q[g] == DIR_S));
    end
endmodule

// File: rtl/coh_mem_array.sv
module coh_mem_array #(
    parameter int N_BLK  = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(N_BLK)-1:0] addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data
);
    logic [DATA_W-1:0] mem_q [N_BLK];

    assign rd_data = mem_q[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BLK; i++) mem_q[i] <= DATA_W'(i);
        end else if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end
endmodule

// File: rtl/coh_inv_pick.sv
module coh_inv_pick #(
    parameter int N_CACHE = 4
) (
    input  logic [N_CACHE-1:0]         mask,
    output logic [$clog2(N_CACHE)-1:0] pick,
    output logic [N_CACHE-1:0]         pick_bit
);
    localparam int ID_W = $clog2(N_CACHE);

    always_comb begin
        pick = '0;
        for (int i = N_CACHE - 1; i >= 0; i--) begin
            if (mask[i]) pick = ID_W'(i);
        end
        pick_bit       = '0;
        pick_bit[pick] = mask[pick];
    end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_BLK   = 16,
    parameter int DATA_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_kind,
    input  logic [$clog2(N_CACHE)-1:0] req_src,
    input  logic [$clog2(N_BLK)-1:0]   req_addr,
    input  logic [DATA_W-1:0]          req_data,
    output logic                       fwd_valid,
    input  logic                       fwd_ready,
    output logic [1:0]                 fwd_kind,
    output logic [$clog2(N_CACHE)-1:0] fwd_dest,
    output logic [$clog2(N_CACHE)-1:0] fwd_req,
    output logic [$clog2(N_BLK)-1:0]   fwd_addr,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic                       rsp_kind,
    output logic [$clog2(N_CACHE)-1:0] rsp_dest,
    output logic [$clog2(N_BLK)-1:0]   rsp_addr,
    output logic [DATA_W-1:0]          rsp_data,
    output logic [$clog2(N_CACHE)-1:0] rsp_acks
);
    localparam int ID_W = $clog2(N_CACHE);
    localparam int AW   = $clog2(N_BLK);

    fsm_e               fsm_q, nx_fsm;
    logic [1:0]         d_st;
    logic [ID_W-1:0]    d_own;
    logic [N_CACHE-1:0] d_sh;
    logic               d_busy;
    logic [DATA_W-1:0]  m_rd;

    logic               dir_we, mem_we, b_set, b_clr, accept;
    logic [1:0]         w_st;
    logic [ID_W-1:0]    w_own;
    logic [N_CACHE-1:0] w_sh, src_bit, own_bit, others, n_inv;
    rsp_kind_e          n_rsp_kind;
    fwd_kind_e          n_fwd_kind;
    logic [ID_W-1:0]    n_acks;
    logic [DATA_W-1:0]  n_data;

    rsp_kind_e          r_rsp_kind;
    fwd_kind_e          r_fwd_kind;
    logic [ID_W-1:0]    r_src, r_fwd_dest, r_acks, pick;
    logic [AW-1:0]      r_addr;
    logic [DATA_W-1:0]  r_data;
    logic [N_CACHE-1:0] r_inv, pick_bit, inv_left;

    coh_dir_table #(.N_CACHE(N_CACHE), .N_BLK(N_BLK)) u_dir (
        .clk(clk), .rst_n(rst_n), .addr(req_addr),
        .rd_st(d_st), .rd_own(d_own), .rd_sh(d_sh), .rd_busy(d_busy),
        .wr_en(dir_we && accept), .wr_st(w_st), .wr_own(w_own), .wr_sh(w_sh),
        .busy_set(b_set && accept), .busy_clr(b_clr && accept)
    );

    coh_mem_array #(.N_BLK(N_BLK), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr(req_addr), .rd_data(m_rd),
        .wr_en(mem_we && accept), .wr_data(req_data)
    );

    coh_inv_pick #(.N_CACHE(N_CACHE)) u_pick (
        .mask(r_inv), .pick(pick), .pick_bit(pick_bit)
    );

    assign req_ready = (fsm_q == FSM_IDLE) && !(d_busy && req_kind_e'(req_kind) != REQ_ODATA);
    assign accept    = req_valid && req_ready;
    assign inv_left  = r_inv & ~pick_bit;

    always_comb begin
        src_bit = '0; src_bit[req_src] = 1'b1;
        own_bit = '0; own_bit[d_own]   = 1'b1;
        others  = d_sh & ~src_bit;
    end

    // Decision taken in FSM_IDLE on the entry read at req_addr
    always_comb begin
        nx_fsm     = FSM_IDLE;
        dir_we     = 1'b0;
        mem_we     = 1'b0;
        b_set      = 1'b0;
        b_clr      = 1'b0;
        w_st       = d_st;
        w_own      = d_own;
        w_sh       = d_sh;
        n_rsp_kind = RSP_DATA;
        n_fwd_kind = FWD_GETS;
        n_acks     = '0;
        n_data     = m_rd;
        n_inv      = '0;
        unique case (req_kind_e'(req_kind))
            REQ_GETS: begin
                if (d_st == DIR_M && d_own == req_src) begin
                    nx_fsm = FSM_RSP; n_rsp_kind = RSP_ACK; n_data = '0;
                end else if (d_st == DIR_M) begin
                    nx_fsm = FSM_FWD; n_fwd_kind = FWD_GETS;
                    dir_we = 1'b1; w_st = DIR_S; w_sh = own_bit | src_bit; b_set = 1'b1;
                end else begin
                    nx_fsm = FSM_RSP;
                    dir_we = 1'b1; w_st = DIR_S; w_sh = d_sh | src_bit;
                end
            end
            REQ_GETM: begin
                if (d_st == DIR_M && d_own == req_src) begin
                    nx_fsm = FSM_RSP; n_rsp_kind = RSP_ACK; n_data = '0;
                end else if (d_st == DIR_M) begin
                    nx_fsm = FSM_FWD; n_fwd_kind = FWD_GETM;
                    dir_we = 1'b1; w_own = req_src;
                end else begin
                    nx_fsm = FSM_RSP;
                    n_acks = ID_W'($countones(others));
                    n_inv  = others;
                    dir_we = 1'b1; w_st = DIR_M; w_own = req_src; w_sh = '0;
                end
            end
            REQ_PUTM: begin
                nx_fsm = FSM_RSP; n_rsp_kind = RSP_ACK; n_data = '0;
                if (d_st == DIR_M && d_own == req_src) begin
                    mem_we = 1'b1;
                    dir_we = 1'b1; w_st = DIR_I; w_own = '0; w_sh = '0;
                end
            end
            REQ_ODATA: begin
                if (d_busy) begin
                    mem_we = 1'b1; b_clr = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= FSM_IDLE;
        end else begin
            unique case (fsm_q)
                FSM_IDLE: if (accept)    fsm_q <= nx_fsm;
                FSM_RSP:  if (rsp_ready) fsm_q <= (r_inv != '0) ? FSM_INV : FSM_IDLE;
                FSM_FWD:  if (fwd_ready) fsm_q <= FSM_IDLE;
                FSM_INV:  if (fwd_ready && inv_left == '0) fsm_q <= FSM_IDLE;
            endcase
        end
    end

    // Message registers loaded on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rsp_kind <= RSP_DATA;
            r_fwd_kind <= FWD_GETS;
            r_src      <= '0;
            r_fwd_dest <= '0;
            r_acks     <= '0;
            r_addr     <= '0;
            r_data     <= '0;
            r_inv      <= '0;
        end else if (fsm_q == FSM_IDLE && accept) begin
            r_rsp_kind <= n_rsp_kind;
            r_fwd_kind <= n_fwd_kind;
            r_src      <= req_src;
            r_fwd_dest <= d_own;
            r_acks     <= n_acks;
            r_addr     <= req_addr;
            r_data     <= n_data;
            r_inv      <= n_inv;
        end else if (fsm_q == FSM_INV && fwd_ready) begin
            r_inv <= inv_left;
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = (fsm_q == FSM_RSP);
        rsp_kind  = r_rsp_kind;
        rsp_dest  = r_src;
        rsp_addr  = r_addr;
        rsp_data  = r_data;
        rsp_acks  = r_acks;
        fwd_valid = (fsm_q == FSM_FWD) || (fsm_q == FSM_INV);
        fwd_kind  = (fsm_q == FSM_INV) ? FWD_INV : r_fwd_kind;
        fwd_dest  = (fsm_q == FSM_INV) ? pick : r_fwd_dest;
        fwd_req   = r_src;
        fwd_addr  = r_addr;
    end

    p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid &&
            $stable({rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks})));

    p_fwd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid &&
            $stable({fwd_kind, fwd_dest, fwd_req, fwd_addr})));

    p_inv_not_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_kind == FWD_INV) |-> (fwd_dest != fwd_req));

    p_fwd_not_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_kind != FWD_INV) |-> (fwd_dest != fwd_req));

    p_no_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || fwd_valid) |-> !req_ready);
endmodule

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = '0;
    logic [1:0] req_src = '0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       fwd_valid, fwd_ready = 1'b1;
    logic [1:0] fwd_kind, fwd_dest, fwd_req;
    logic [3:0] fwd_addr;
    logic       rsp_valid, rsp_ready = 1'b1;
    logic       rsp_kind;
    logic [1:0] rsp_dest, rsp_acks;
    logic [3:0] rsp_addr;
    logic [7:0] rsp_data;

    int errors = 0;
    int checks = 0;
    bit bp_en  = 1'b0;

    // Reference model
    int         m_st   [16];
    int         m_own  [16];
    logic [3:0] m_sh   [16];
    bit         m_busy [16];
    logic [7:0] m_mem  [16];
    logic [16:0] exp_rsp [$];
    string       tag_rsp [$];
    logic [9:0]  exp_fwd [$];
    string       tag_fwd [$];

    coh_home_dir i_coh_home_dir (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_kind(fwd_kind),
        .fwd_dest(fwd_dest), .fwd_req(fwd_req), .fwd_addr(fwd_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_dest(rsp_dest), .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_acks(rsp_acks)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void push_rsp(input bit k, input int d, input int a, input logic [7:0] v,
                                     input int n, input string t);
        exp_rsp.push_back({k, 2'(d), 4'(a), v, 2'(n)});
        tag_rsp.push_back(t);
    endfunction

    function automatic void push_fwd(input int k, input int d, input int r, input int a, input string t);
        exp_fwd.push_back({2'(k), 2'(d), 2'(r), 4'(a)});
        tag_fwd.push_back(t);
    endfunction

    function automatic void model(input int t, input int s, input int a, input logic [7:0] d);
        logic [3:0] oth;
        int n;
        case (t)
            0: if (m_st[a] == 2 && m_own[a] == s) push_rsp(1, s, a, 8'h00, 0, "R10");
               else if (m_st[a] == 2) begin
                   push_fwd(0, m_own[a], s, a, "R6");
                   m_sh[a] = 4'(1 << m_own[a]) | 4'(1 << s);
                   m_st[a] = 1; m_busy[a] = 1'b1;
               end else begin
                   push_rsp(0, s, a, m_mem[a], 0, "R2");
                   m_st[a] = 1; m_sh[a] = m_sh[a] | 4'(1 << s);
               end
            1: if (m_st[a] == 2 && m_own[a] == s) push_rsp(1, s, a, 8'h00, 0, "R10");
               else if (m_st[a] == 2) begin
                   push_fwd(1, m_own[a], s, a, "R5");
                   m_own[a] = s;
               end else begin
                   oth = m_sh[a] & ~4'(1 << s);
                   n = 0;
                   for (int i = 0; i < 4; i++) if (oth[i]) n++;
                   push_rsp(0, s, a, m_mem[a], n, (m_st[a] == 1) ? "R4" : "R3");
                   for (int i = 0; i < 4; i++) if (oth[i]) push_fwd(2, i, s, a, "R4");
                   m_st[a] = 2; m_own[a] = s; m_sh[a] = '0;
               end
            2: if (m_st[a] == 2 && m_own[a] == s) begin
                   push_rsp(1, s, a, 8'h00, 0, "R8");
                   m_mem[a] = d; m_st[a] = 0;
               end else push_rsp(1, s, a, 8'h00, 0, "R9");
            default: if (m_busy[a]) begin
                   m_mem[a] = d; m_busy[a] = 1'b0;
               end
        endcase
    endfunction

    task automatic send(input int t, input int s, input int a, input logic [7:0] d);
        @(negedge clk);
        req_kind = 2'(t); req_src = 2'(s); req_addr = 4'(a); req_data = d; req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        model(t, s, a, d);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_rsp.size() != 0 || exp_fwd.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Backpressure driver, away from the active edge
    initial forever begin
        @(posedge clk); #1;
        rsp_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
        fwd_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
    end

    // Monitor: compares every accepted message and checks hold under stall
    logic        rsp_stall_q = 1'b0, fwd_stall_q = 1'b0;
    logic [16:0] rsp_prev;
    logic [9:0]  fwd_prev;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (rsp_stall_q)  // R12
                check(rsp_valid && {rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks} == rsp_prev,
                      "R12 rsp hold", {rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks}, rsp_prev);
            if (fwd_stall_q)  // R12
                check(fwd_valid && {fwd_kind, fwd_dest, fwd_req, fwd_addr} == fwd_prev,
                      "R12 fwd hold", {fwd_kind, fwd_dest, fwd_req, fwd_addr}, fwd_prev);
            if (rsp_valid && rsp_ready) begin
                if (exp_rsp.size() == 0)
                    check(1'b0, "R12 unexpected rsp", {rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks}, 0);
                else begin
                    automatic logic [16:0] e = exp_rsp.pop_front();
                    automatic string t = tag_rsp.pop_front();
                    check({rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks} == e, t,
                          {rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks}, e);
                end
            end
            if (fwd_valid && fwd_ready) begin
                if (exp_fwd.size() == 0 || exp_rsp.size() != 0)
                    check(1'b0, "R4 unexpected or early fwd", {fwd_kind, fwd_dest, fwd_req, fwd_addr}, 0);
                else begin
                    automatic logic [9:0] e = exp_fwd.pop_front();
                    automatic string t = tag_fwd.pop_front();
                    check({fwd_kind, fwd_dest, fwd_req, fwd_addr} == e, t,
                          {fwd_kind, fwd_dest, fwd_req, fwd_addr}, e);
                end
            end
            rsp_stall_q = rsp_valid && !rsp_ready;
            fwd_stall_q = fwd_valid && !fwd_ready;
            rsp_prev = {rsp_kind, rsp_dest, rsp_addr, rsp_data, rsp_acks};
            fwd_prev = {fwd_kind, fwd_dest, fwd_req, fwd_addr};
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_st[i] = 0; m_own[i] = 0; m_sh[i] = '0; m_busy[i] = 1'b0; m_mem[i] = 8'(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        check(rsp_valid == 1'b0 && fwd_valid == 1'b0, "R1 outputs idle", {rsp_valid, fwd_valid}, 0);

        send(0, 0, 5, 8'h00);   // R1 memory value, R2 GetS in I
        send(0, 1, 5, 8'h00);   // R2 GetS in S
        send(1, 2, 5, 8'h00);   // R4 two invalidations
        send(1, 3, 5, 8'h00);   // R5 forward, R13 no sharers left
        send(0, 3, 5, 8'h00);   // R10 owner GetS
        send(1, 3, 5, 8'h00);   // R10 owner GetM
        send(2, 1, 5, 8'h77);   // R9 non-owner PutM
        send(0, 0, 5, 8'h00);   // R6 forward to owner, busy

        // R7: stalled while busy
        @(negedge clk);
        req_kind = 2'd1; req_src = 2'd1; req_addr = 4'd5; req_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1; check(req_ready == 1'b0, "R7 stall on busy block", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        send(0, 1, 9, 8'h00);   // R7 other block accepted
        send(3, 3, 5, 8'h3C);   // R7 owner data clears busy
        send(0, 1, 5, 8'h00);   // R7 data returned by owner
        send(1, 0, 5, 8'h00);   // R4 invalidate c1 then c3
        send(2, 0, 5, 8'hE1);   // R8 write-back
        send(0, 2, 5, 8'h00);   // R8 data written back, R2 from I
        send(3, 0, 7, 8'hFF);   // R11 ignored
        #1; check(rsp_valid == 1'b0 && fwd_valid == 1'b0, "R11 no output", {rsp_valid, fwd_valid}, 0);
        send(0, 0, 7, 8'h00);   // R11 memory unchanged
        send(1, 2, 12, 8'h00);  // R3 GetM in I

        bp_en = 1'b1;           // R12 backpressure
        send(1, 1, 7, 8'h00);
        send(0, 2, 7, 8'h00);

        for (int n = 0; n < 120; n++) begin
            automatic int a = $urandom % 4;
            automatic int s = $urandom % 4;
            automatic int t = $urandom % 3;
            bp_en = (n % 2) == 1;
            if (m_busy[a]) t = 3;
            send(t, s, a, 8'($urandom));
        end
        bp_en = 1'b0;
        for (int a = 0; a < 4; a++) begin
            if (m_busy[a]) send(3, 0, a, 8'h5A);
            send(0, 3, a, 8'h00);  // R13 final probe of each block
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule